// File: doc/BRIEF.md
# Pin I/O Controller with Per-Pin Interrupt Detection

This block gives software control over a set of general-purpose pins, up to 96 of them. Each pin has a direction bit, a drive value and an interrupt setup. The setup chooses level or edge detection, selects the active sense, and enables the pin in any of four independent interrupt groups. Every per-pin setting sits in a bank of 32-bit words, one word for each group of 32 pins. The words of a bank are at consecutive word addresses.

Pin inputs pass through a two-stage synchronizer before use. Detected events latch into a per-pin status bit. Software clears a status bit by writing a 1 to it. Each of the four enable groups drives its own interrupt line. That line is high whenever any latched status bit is also enabled in the group. Register reads are combinational from the word address, and writes take effect on the next rising clock edge.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Pin n is bit (n mod 32) of word (bank base + n/32). The bank bases, as word addresses, are: direction 5, drive 9, the four enable groups 17, 21, 25 and 29, sense 65, detect-type 69 and status 73. Every bank except drive reads back the value last written.
- R2: Bits for pins at or above NUM_PINS read as 0. Addresses outside all banks read as 0, and writes to them change nothing.
- R3: While reset is held, all direction, drive, enable, sense, type and status bits clear. pin_oe, pin_out and irq are then all 0.
- R4: pin_oe follows the direction bank (1 = drive the pin). pin_out follows the drive bank.
- R5: Reading a drive word returns the pin_in values after the two-flop synchronizer, not the written drive values. A change on pin_in is visible after the second rising edge.
- R6: A type bit of 0 selects level detection. With sense 0 the status bit sets while the synchronized input is 1. With sense 1 it sets while the input is 0.
- R7: A type bit of 1 selects edge detection. Sense 0 catches rising edges and sense 1 catches falling edges. An edge on pin_in shows in status after the third rising edge, and never after only the second.
- R8: Writing 1 to a status bit clears it on that edge. Writing 0 leaves it unchanged. If a level condition is still active, the status bit sets again one cycle later. An edge-type bit stays clear until a new edge arrives.
- R9: irq[b] equals the OR over all pins of (status AND enable-group b). Status latches whether or not any enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed word (combinational) |
| pin_in | input | NUM_PINS | Pin input values (asynchronous) |
| pin_out | output | NUM_PINS | Drive value per pin |
| pin_oe | output | NUM_PINS | Output enable per pin |
| irq | output | 4 | One interrupt line per enable group |

## Verification
The assertions run on every cycle and check the following. Reset quiets all outputs. A direction write shows on pin_oe on the next cycle. A clear empties the addressed status bit on the next cycle. An edge-type status bit never rises without a synchronized transition. An interrupt line is never high without both an enable and a latched status bit. Only the bench scenarios can show these points: the exact latency from pin to status, the difference between level re-assertion and edge behaviour after a clear, the sense selection, and the masking of unmapped addresses and missing pins.

// File: rtl/gpio_irq_pkg.sv
// Shared definitions for the pin I/O controller: bank base word
// addresses and the address decoder. Assumes at most three words per bank.
package gpio_irq_pkg;

    localparam int N_BANKS   = 4;
    localparam int IDX_W     = 2;
    localparam int BASE_OE   = 5;
    localparam int BASE_DRV  = 9;
    localparam int BASE_EN   = 17;
    localparam int EN_STRIDE = 4;
    localparam int BASE_POL  = 65;
    localparam int BASE_TYPE = 69;
    localparam int BASE_STAT = 73;

    typedef enum logic [2:0] {
        F_NONE, F_OE, F_DRV, F_EN, F_POL, F_TYPE, F_STAT
    } feat_e;

    typedef struct packed {
        feat_e            feat;
        logic [1:0]       bank;
        logic [IDX_W-1:0] word;
    } dec_t;

    // Map a word address to a feature, enable group and word index.
    function automatic dec_t decode_addr(input int a, input int words);
        dec_t d;
        d      = '0;
        d.feat = F_NONE;
        if (a >= BASE_OE && a < BASE_OE + words) begin
            d.feat = F_OE;   d.word = IDX_W'(a - BASE_OE);
        end
        if (a >= BASE_DRV && a < BASE_DRV + words) begin
            d.feat = F_DRV;  d.word = IDX_W'(a - BASE_DRV);
        end
        for (int b = 0; b < N_BANKS; b++) begin
            if (a >= BASE_EN + b*EN_STRIDE && a < BASE_EN + b*EN_STRIDE + words) begin
                d.feat = F_EN;
                d.bank = 2'(b);
                d.word = IDX_W'(a - BASE_EN - b*EN_STRIDE);
            end
        end
        if (a >= BASE_POL && a < BASE_POL + words) begin
            d.feat = F_POL;  d.word = IDX_W'(a - BASE_POL);
        end
        if (a >= BASE_TYPE && a < BASE_TYPE + words) begin
            d.feat = F_TYPE; d.word = IDX_W'(a - BASE_TYPE);
        end
        if (a >= BASE_STAT && a < BASE_STAT + words) begin
            d.feat = F_STAT; d.word = IDX_W'(a - BASE_STAT);
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchronizer for a vector of asynchronous pin inputs.
// Assumes each bit is independent; no bus coherency is implied.
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages toward the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gpio_word_bank.sv
// One per-pin setting bank, stored as 32-bit words. Only bits that map
// to existing pins are stored; writes are word-wide with a one-hot enable.
module gpio_word_bank #(
    parameter int NUM_PINS = 70,
    parameter int WORDS    = (NUM_PINS + 31) / 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [WORDS-1:0]    we,
    input  logic [31:0]         wdata,
    output logic [NUM_PINS-1:0] q
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        localparam int LO  = w * 32;
        localparam int WID = (NUM_PINS - LO > 32) ? 32 : (NUM_PINS - LO);
        logic [WID-1:0] r;

        // Hold the word; load the pin-mapped slice of write data.
        always_ff @(posedge clk) begin
            if (!rst_n)     r <= '0;
            else if (we[w]) r <= wdata[WID-1:0];
        end
        assign q[LO +: WID] = r;
    end
endmodule

// File: rtl/gpio_irq_detect.sv
// Per-pin interrupt detection and status latching. Inputs are already
// synchronized. A clear takes priority over a new hit in the same cycle.
module gpio_irq_detect #(
    parameter int NUM_PINS = 70
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] sync_v,
    input  logic [NUM_PINS-1:0] typ,
    input  logic [NUM_PINS-1:0] pol,
    input  logic [NUM_PINS-1:0] clr,
    output logic [NUM_PINS-1:0] prev_v,
    output logic [NUM_PINS-1:0] stat
);
    logic [NUM_PINS-1:0] lvl_hit, rise, fall, edge_hit, hit;

    // Form the level and edge conditions per pin.
    always_comb begin
        lvl_hit  = sync_v ^ pol;
        rise     = sync_v & ~prev_v;
        fall     = ~sync_v & prev_v;
        edge_hit = (~pol & rise) | (pol & fall);
        hit      = (typ & edge_hit) | (~typ & lvl_hit);
    end

    // Keep the last sample and latch status with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_v <= '0;
            stat   <= '0;
        end else begin
            prev_v <= sync_v;
            stat   <= (stat | hit) & ~clr;
        end
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
// Top of the pin I/O controller: decodes word accesses, holds the per-pin
// banks, synchronizes inputs, detects events and drives four interrupt lines.
// Assumes NUM_PINS <= 96 and that addr covers word 75.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 70,
    parameter int ADDR_W   = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [N_BANKS-1:0]  irq
);
    localparam int WORDS = (NUM_PINS + 31) / 32;
    localparam int PAD_W = WORDS * 32;

    dec_t                       dec;
    logic [WORDS-1:0]           we_oe, we_drv, we_pol, we_type, we_stat;
    logic [WORDS-1:0]           we_en [N_BANKS];
    logic [NUM_PINS-1:0]        oe_bits, drv_bits, pol_bits, type_bits;
    logic [N_BANKS*NUM_PINS-1:0] en_flat;
    logic [NUM_PINS-1:0]        pin_sync, pin_prev, stat_q, stat_clr;
    logic [PAD_W-1:0]           sel;

    assign dec = decode_addr(int'(addr), WORDS);

    // Turn the decoded access into per-word write enables.
    always_comb begin
        we_oe = '0; we_drv = '0; we_pol = '0; we_type = '0; we_stat = '0;
        for (int b = 0; b < N_BANKS; b++) we_en[b] = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (wr_en && int'(dec.word) == w) begin
                we_oe[w]   = (dec.feat == F_OE);
                we_drv[w]  = (dec.feat == F_DRV);
                we_pol[w]  = (dec.feat == F_POL);
                we_type[w] = (dec.feat == F_TYPE);
                we_stat[w] = (dec.feat == F_STAT);
                for (int b = 0; b < N_BANKS; b++)
                    we_en[b][w] = (dec.feat == F_EN) && (int'(dec.bank) == b);
            end
        end
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_clr
        assign stat_clr[i] = we_stat[i / 32] & wdata[i % 32];
    end

    gpio_word_bank #(.NUM_PINS(NUM_PINS), .WORDS(WORDS)) u_oe (
        .clk(clk), .rst_n(rst_n), .we(we_oe), .wdata(wdata), .q(oe_bits));
    gpio_word_bank #(.NUM_PINS(NUM_PINS), .WORDS(WORDS)) u_drv (
        .clk(clk), .rst_n(rst_n), .we(we_drv), .wdata(wdata), .q(drv_bits));
    gpio_word_bank #(.NUM_PINS(NUM_PINS), .WORDS(WORDS)) u_pol (
        .clk(clk), .rst_n(rst_n), .we(we_pol), .wdata(wdata), .q(pol_bits));
    gpio_word_bank #(.NUM_PINS(NUM_PINS), .WORDS(WORDS)) u_type (
        .clk(clk), .rst_n(rst_n), .we(we_type), .wdata(wdata), .q(type_bits));

    for (genvar b = 0; b < N_BANKS; b++) begin : g_en
        gpio_word_bank #(.NUM_PINS(NUM_PINS), .WORDS(WORDS)) u_en (
            .clk(clk), .rst_n(rst_n), .we(we_en[b]), .wdata(wdata),
            .q(en_flat[b*NUM_PINS +: NUM_PINS]));
        assign irq[b] = |(stat_q & en_flat[b*NUM_PINS +: NUM_PINS]);
    end

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync));

    gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_det (
        .clk(clk), .rst_n(rst_n), .sync_v(pin_sync), .typ(type_bits),
        .pol(pol_bits), .clr(stat_clr), .prev_v(pin_prev), .stat(stat_q));

    assign pin_out = drv_bits;
    assign pin_oe  = oe_bits;

    // Select the addressed bank, zero-padded, then the addressed word.
    always_comb begin
        case (dec.feat)
            F_OE:    sel = PAD_W'(oe_bits);
            F_DRV:   sel = PAD_W'(pin_sync);
            F_EN:    sel = PAD_W'(en_flat[int'(dec.bank)*NUM_PINS +: NUM_PINS]);
            F_POL:   sel = PAD_W'(pol_bits);
            F_TYPE:  sel = PAD_W'(type_bits);
            F_STAT:  sel = PAD_W'(stat_q);
            default: sel = '0;
        endcase
        rdata = sel[32*int'(dec.word) +: 32];
    end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
// Checker for gpio_irq_ctrl, bound to every instance. It watches ports and
// the signals between the synchronizer, the banks and the detector.
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 70,
    parameter int ADDR_W   = 7
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           addr,
    input logic [31:0]                 wdata,
    input logic [NUM_PINS-1:0]         pin_oe,
    input logic [N_BANKS-1:0]          irq,
    input logic [NUM_PINS-1:0]         stat,
    input logic [NUM_PINS-1:0]         typ,
    input logic [NUM_PINS-1:0]         sync_v,
    input logic [NUM_PINS-1:0]         prev_v,
    input logic [NUM_PINS-1:0]         clr,
    input logic [N_BANKS*NUM_PINS-1:0] en_flat
);
    localparam int LOW_W = (NUM_PINS < 32) ? NUM_PINS : 32;

    // R3: a reset cycle leaves outputs and status quiet
    a_r3_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && irq == '0 && stat == '0));

    // R4: a direction write to word 0 appears on pin_oe next cycle
    a_r4_oe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(BASE_OE)) |=>
            (pin_oe[LOW_W-1:0] == $past(wdata[LOW_W-1:0])));

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        // R9: an interrupt line needs an enable and a latched status
        a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
            irq[b] |-> ((|en_flat[b*NUM_PINS +: NUM_PINS]) && (|stat)));
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        // R8: a clear empties the status bit on the next cycle
        a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
            clr[i] |=> !stat[i]);
        // R7: edge-type status only rises after a synchronized transition
        a_r7_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(typ[i]) && $rose(stat[i])) |->
                ($past(sync_v[i]) != $past(prev_v[i])));
    end
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pin_oe(pin_oe), .irq(irq), .stat(stat_q), .typ(type_bits),
    .sync_v(pin_sync), .prev_v(pin_prev), .clr(stat_clr), .en_flat(en_flat));

// File: tb/test_gpio_irq_ctrl.sv
// Self-checking bench: a table of register write/read-back vectors, then
// directed tests for reset, drive, sense, edge, clear and interrupt lines.
module test_gpio_irq_ctrl;
    localparam int NP = 70;
    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [AW-1:0] addr;
    logic [31:0]   wdata;
    logic [31:0]   rdata;
    logic [NP-1:0] pin_in;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic [3:0]    irq;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    gpio_irq_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) i_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq(irq));

    typedef struct packed {
        logic [AW-1:0] a;
        logic [31:0]   d;
        logic [31:0]   e;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{7'd5,   32'hA5A5_0F0F, 32'hA5A5_0F0F}, // R1 direction word 0
        '{7'd7,   32'hFFFF_FFFF, 32'h0000_003F}, // R2 pins 70..95 absent
        '{7'd8,   32'h1234_5678, 32'h0000_0000}, // R2 gap address
        '{7'd70,  32'h0F0F_0000, 32'h0F0F_0000}, // R1 type word 1
        '{7'd70,  32'h0000_0000, 32'h0000_0000}, // R1 type restored
        '{7'd26,  32'hDEAD_BEEF, 32'hDEAD_BEEF}, // R1 enable group 2 word 1
        '{7'd31,  32'hFFFF_FFFF, 32'h0000_003F}, // R2 enable group 3 word 2
        '{7'd32,  32'hFFFF_FFFF, 32'h0000_0000}, // R2 past last enable word
        '{7'd127, 32'hFFFF_FFFF, 32'h0000_0000}, // R2 top address
        '{7'd26,  32'h0000_0000, 32'h0000_0000}, // R1 clear enable group 2
        '{7'd31,  32'h0000_0000, 32'h0000_0000}  // R1 clear enable group 3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr(input int a, input logic [31:0] d);
        addr = AW'(a); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        addr = AW'(a);
        #1 d = rdata;
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual running expected done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; pin_in = '0;
        ticks(3);
        // R3: outputs quiet in reset
        chk("R3 pin_oe", pin_oe[31:0], 32'h0);
        chk("R3 irq", {28'h0, irq}, 32'h0);
        rst_n = 1'b1;
        ticks(1);
        rd(73, v); chk("R3 status word 0", v, 32'h0);
        rd(5, v);  chk("R3 direction word 0", v, 32'h0);

        // R1/R2 table walk
        foreach (VECS[k]) begin
            wr(int'(VECS[k].a), VECS[k].d);
            rd(int'(VECS[k].a), v);
            chk($sformatf("R1/R2 vector %0d", k), v, VECS[k].e);
        end

        // R4: ports follow the banks
        wr(9, 32'h0000_0001);
        chk("R4 pin_out", pin_out[31:0], 32'h0000_0001);
        chk("R4 pin_oe", pin_oe[31:0], 32'hA5A5_0F0F);
        chk("R4 pin_oe word 2", {26'h0, pin_oe[69:64]}, 32'h3F);
        // R5: drive word reads pins, not drive values
        rd(9, v); chk("R5 drive word reads pins", v, 32'h0);

        // R6 level high on pin 3, with R7-style latency
        pin_in[3] = 1'b1;
        ticks(2);
        rd(73, v); chk("R6 status not yet", v, 32'h0);
        ticks(1);
        rd(73, v); chk("R6 level high latched", v, 32'h8);
        chk("R9 no enable no irq", {28'h0, irq}, 32'h0);
        wr(21, 32'h8);
        chk("R9 group 1 irq", {28'h0, irq}, 32'h2);
        // R8: clear wins, then level re-sets
        wr(73, 32'h8);
        rd(73, v); chk("R8 cleared on write edge", v, 32'h0);
        ticks(1);
        rd(73, v); chk("R8 level re-sets", v, 32'h8);
        pin_in[3] = 1'b0;
        ticks(4);
        wr(73, 32'h8);
        ticks(2);
        rd(73, v); chk("R8 stays clear after level gone", v, 32'h0);
        chk("R9 irq drops", {28'h0, irq}, 32'h0);

        // R7 falling edge on pin 40 (word 1 bit 8)
        wr(70, 32'h100);
        wr(66, 32'h100);
        pin_in[40] = 1'b1;
        ticks(4);
        rd(74, v); chk("R7 rising ignored with sense 1", v, 32'h0);
        pin_in[40] = 1'b0;
        ticks(2);
        rd(74, v); chk("R7 falling not after two edges", v, 32'h0);
        ticks(1);
        rd(74, v); chk("R7 falling edge latched", v, 32'h100);
        wr(74, 32'h100);
        ticks(2);
        rd(74, v); chk("R8 edge stays clear", v, 32'h0);

        // R7 rising edge on pin 66 (word 2 bit 2), group 3
        wr(71, 32'h4);
        pin_in[66] = 1'b1;
        ticks(4);
        rd(75, v); chk("R7 rising edge latched", v, 32'h4);
        wr(75, 32'h0);
        rd(75, v); chk("R8 zero write no effect", v, 32'h4);
        wr(31, 32'h4);
        chk("R9 group 3 irq", {28'h0, irq}, 32'h8);

        // R6 level low on pin 5
        wr(65, 32'h20);
        ticks(1);
        rd(73, v); chk("R6 level low latched", v, 32'h20);

        // R5: pin 33 readable through drive word 1
        pin_in[33] = 1'b1;
        ticks(2);
        rd(10, v); chk("R5 pin value read", v, 32'h2);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule